// File: doc/BRIEF.md
# Paged Peripheral-to-System Address Translator

This block sits between a 16-bit style peripheral bus with 24/32-bit byte addresses and a wide system bus addressed in 32-bit words. Each memory cycle that the peripheral side issues is looked up in one of three page maps. The map is chosen by the address window the cycle falls in. The block returns a system word address, the two low byte-address bits as a separate byte offset, and a miss flag. The peripheral bus cannot report a bus error, so a cycle that falls in no window, or that hits an entry not marked valid, is flagged as a miss. It is not faulted.

The three windows differ greatly in granularity:
- **Small window.** A movable 64 KB region inside the first megabyte, cut into sixteen 4 KB pages. It serves the processor on the peripheral side.
- **Middle window.** The span from 1 MB up to 15 MB, with fourteen 1 MB pages. It serves peripheral DMA.
- **Large window.** Everything from 16 MB upward, using 256 MB pages. Entry 0 covers only the partial page from 16 MB to 256 MB, and entries 1 to 15 are full pages.

Every map has 16 entries. Each entry holds a valid bit and a page frame number.

Both bus masters can load the maps and the window base, through two identical write ports. A small arbitration state machine orders the writes, and the system-side port has priority. It has two states:
- **ARB_OPEN.** Either port's write is applied in the cycle it is offered. When both ports write in the same cycle, the system write is applied, the peripheral write is captured, and the machine moves to ARB_HOLD.
- **ARB_HOLD.** The captured write waits, and `per_wr_stall` is high. If the system side writes again, that write is applied and the machine stays in ARB_HOLD. Otherwise the captured write is applied and the machine returns to ARB_OPEN.

Top module: `iob_page_xlate`

## Requirements
- R1: After reset every map entry is invalid, the window base is 0, all outputs are 0 and `per_wr_stall` is 0, so every request misses.
- R2: An address with bits [31:20] zero and bits [19:16] equal to the window base hits the small map at index addr[15:12]; the word address is {frame[21:0], addr[11:2]}.
- R3: An address with bits [31:24] zero and bits [23:20] in 1..14 hits the middle map at index addr[23:20]-1; the word address is {frame[13:0], addr[19:2]}.
- R4: An address of 0x0100_0000 or above hits the large map at index addr[31:28]; the word address is {frame[5:0], addr[27:2]}.
- R5: On every valid output `xo_byte_off` equals bits [1:0] of the request address.
- R6: A request outside all windows (inside the first MB but off the small window, or in 15 MB..16 MB), or one hitting an invalid entry, gives `xo_miss`=1 and a word address of 0.
- R7: Results appear one cycle after the request: `xo_valid` follows `req_valid` by one clock, and with no request all result outputs are 0.
- R8: A write carries a select (0 small map, 1 middle map, 2 large map, 3 window base), a 4-bit index and 23 data bits. Bit 22 is the valid bit and bits [21:0] are the frame; each map keeps the low 22/14/6 bits. For the base, bits [3:0] are used. Both ports use this encoding.
- R9: A write takes effect at the clock edge that accepts it; a request sampled at that same edge is translated with the old contents.
- R10: When both ports write in one cycle, the system write is applied at once. The peripheral write is applied one cycle later, and `per_wr_stall` is high during that cycle.
- R11: A system write during a stall cycle is applied at once, the peripheral write stays held and `per_wr_stall` stays high for another cycle.
- R12: A peripheral write offered while `per_wr_stall` is high is discarded.
- R13: Changing the window base moves the small window: the old region misses and the new region translates through the same entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Peripheral byte address |
| sys_wr_en | input | 1 | System-side write strobe |
| sys_wr_sel | input | 2 | System-side target select |
| sys_wr_idx | input | 4 | System-side entry index |
| sys_wr_data | input | 23 | System-side data (valid, frame or base) |
| per_wr_en | input | 1 | Peripheral-side write strobe |
| per_wr_sel | input | 2 | Peripheral-side target select |
| per_wr_idx | input | 4 | Peripheral-side entry index |
| per_wr_data | input | 23 | Peripheral-side data |
| per_wr_stall | output | 1 | Peripheral write is held this cycle |
| xo_valid | output | 1 | Translation result valid |
| xo_word_addr | output | 32 | Translated system word address |
| xo_byte_off | output | 2 | Byte offset within the word |
| xo_miss | output | 1 | No window or invalid entry |

## Verification
A corrupted map entry or window base shows up at the ports on the very next request that lands in that page. The result is a wrong frame in the upper word-address bits, or a false miss, one clock after the request. A fault in the arbitration state shows within two cycles of a write collision. It appears as a wrong `per_wr_stall` level, or as a later translation that returns the losing or the dropped write's frame. The bench sweeps every page index of all three maps at several in-page offsets, and probes each window edge. It compares every result against an arithmetic model fed with what the bench itself wrote.

// File: rtl/xl_pkg.sv
package xl_pkg;
    parameter int PA_W     = 32;   // peripheral byte address width
    parameter int WA_W     = 32;   // system word address width
    parameter int ENTRIES  = 16;   // entries per map
    parameter int SM_SH    = 12;   // small page shift (4 KB)
    parameter int MID_SH   = 20;   // middle page shift (1 MB)
    parameter int LG_SH    = 28;   // large page shift (256 MB)
    parameter int MID_TOP  = 24;   // first address bit above the middle window

    localparam int IDX_W     = $clog2(ENTRIES);
    localparam int SM_WIN_SH = SM_SH + IDX_W;          // small window size shift
    localparam int BASE_W    = MID_SH - SM_WIN_SH;     // base register width
    localparam int SM_FR_W   = WA_W - (SM_SH - 2);
    localparam int MID_FR_W  = WA_W - (MID_SH - 2);
    localparam int LG_FR_W   = WA_W - (LG_SH - 2);
    localparam int WDATA_W   = SM_FR_W + 1;            // valid + widest frame

    typedef enum logic [1:0] {
        TGT_SMALL = 2'd0,
        TGT_MID   = 2'd1,
        TGT_LARGE = 2'd2,
        TGT_BASE  = 2'd3
    } tgt_sel_e;

    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic               we;
        tgt_sel_e           sel;
        logic [IDX_W-1:0]   idx;
        logic [WDATA_W-1:0] data;
    } wr_cmd_t;
endpackage

// File: rtl/xl_win_decode.sv
module xl_win_decode
    import xl_pkg::*;
(
    input  logic [PA_W-1:0]   addr,
    input  logic [BASE_W-1:0] base,
    output logic              hit_sm,
    output logic              hit_mid,
    output logic              hit_lg,
    output logic [IDX_W-1:0]  idx_sm,
    output logic [IDX_W-1:0]  idx_mid,
    output logic [IDX_W-1:0]  idx_lg
);
    logic [IDX_W-1:0] mid_field;
    logic             below_1m;
    logic             below_top;

    always_comb begin
        below_1m  = (addr[PA_W-1:MID_SH] == '0);
        below_top = (addr[PA_W-1:MID_TOP] == '0);
        mid_field = addr[MID_SH+IDX_W-1:MID_SH];

        hit_sm  = below_1m && (addr[MID_SH-1:SM_WIN_SH] == base);
        hit_mid = below_top && (mid_field != '0) && (mid_field != '1);
        hit_lg  = !below_top;

        idx_sm  = addr[SM_SH+IDX_W-1:SM_SH];
        idx_mid = mid_field - IDX_W'(1);
        idx_lg  = addr[LG_SH+IDX_W-1:LG_SH];
    end

    // Windows never overlap
    always_comb begin
        assert_windows_disjoint_R6: assert ($countones({hit_sm, hit_mid, hit_lg}) <= 1)
            else $error("two windows hit at once");
    end
endmodule

// File: rtl/xl_map_bank.sv
module xl_map_bank
    import xl_pkg::*;
#(
    parameter int FR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [FR_W-1:0]  wr_frame,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [FR_W-1:0]  rd_frame
);
    logic [ENTRIES-1:0]           ent_v;
    logic [ENTRIES-1:0][FR_W-1:0] ent_f;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
            ent_f <= '0;
        end else if (wr_en) begin
            ent_v[wr_idx] <= wr_valid;
            ent_f[wr_idx] <= wr_frame;
        end
    end

    always_comb begin
        rd_valid = ent_v[rd_idx];
        rd_frame = ent_f[rd_idx];
    end

    // An accepted write is visible in the entry after the edge
    assert_entry_loaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_v[$past(wr_idx)] == $past(wr_valid)) &&
                  (ent_f[$past(wr_idx)] == $past(wr_frame)))
        else $error("map entry not loaded");
endmodule

// File: rtl/xl_wr_arb.sv
module xl_wr_arb
    import xl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wr_cmd_t sys_cmd,
    input  wr_cmd_t per_cmd,
    output wr_cmd_t cmd_o,
    output logic    stall_o
);
    arb_state_e state_q, state_d;
    wr_cmd_t    held_q;
    logic       capture;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_OPEN;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) held_q <= per_cmd;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        cmd_o   = '0;
        stall_o = 1'b0;
        unique case (state_q)
            ARB_OPEN: begin
                if (sys_cmd.we) begin
                    cmd_o = sys_cmd;
                    if (per_cmd.we) begin
                        capture = 1'b1;
                        state_d = ARB_HOLD;
                    end
                end else if (per_cmd.we) begin
                    cmd_o = per_cmd;
                end
            end
            ARB_HOLD: begin
                stall_o = 1'b1;
                if (sys_cmd.we) begin
                    cmd_o = sys_cmd;
                end else begin
                    cmd_o   = held_q;
                    state_d = ARB_OPEN;
                end
            end
            default: state_d = ARB_OPEN;
        endcase
    end

    assert_clash_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_cmd.we && per_cmd.we && !stall_o) |=> stall_o)
        else $error("collision did not stall peripheral write");

    assert_stall_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !sys_cmd.we) |=> !stall_o)
        else $error("stall held longer than needed");

    assert_stall_extends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && sys_cmd.we) |=> stall_o)
        else $error("held write dropped under system write");
endmodule

// File: rtl/iob_page_xlate.sv
module iob_page_xlate
    import xl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [PA_W-1:0]     req_addr,
    input  logic                sys_wr_en,
    input  logic [1:0]          sys_wr_sel,
    input  logic [IDX_W-1:0]    sys_wr_idx,
    input  logic [WDATA_W-1:0]  sys_wr_data,
    input  logic                per_wr_en,
    input  logic [1:0]          per_wr_sel,
    input  logic [IDX_W-1:0]    per_wr_idx,
    input  logic [WDATA_W-1:0]  per_wr_data,
    output logic                per_wr_stall,
    output logic                xo_valid,
    output logic [WA_W-1:0]     xo_word_addr,
    output logic [1:0]          xo_byte_off,
    output logic                xo_miss
);
    wr_cmd_t sys_cmd, per_cmd, cmd;

    always_comb begin
        sys_cmd = {sys_wr_en, tgt_sel_e'(sys_wr_sel), sys_wr_idx, sys_wr_data};
        per_cmd = {per_wr_en, tgt_sel_e'(per_wr_sel), per_wr_idx, per_wr_data};
    end

    xl_wr_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .sys_cmd (sys_cmd),
        .per_cmd (per_cmd),
        .cmd_o   (cmd),
        .stall_o (per_wr_stall)
    );

    // window base register
    logic [BASE_W-1:0] base_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               base_q <= '0;
        else if (cmd.we && cmd.sel == TGT_BASE)   base_q <= cmd.data[BASE_W-1:0];
    end

    logic             hit_sm, hit_mid, hit_lg;
    logic [IDX_W-1:0] idx_sm, idx_mid, idx_lg;

    xl_win_decode u_dec (
        .addr    (req_addr),
        .base    (base_q),
        .hit_sm  (hit_sm),
        .hit_mid (hit_mid),
        .hit_lg  (hit_lg),
        .idx_sm  (idx_sm),
        .idx_mid (idx_mid),
        .idx_lg  (idx_lg)
    );

    logic                sm_v, mid_v, lg_v;
    logic [SM_FR_W-1:0]  sm_f;
    logic [MID_FR_W-1:0] mid_f;
    logic [LG_FR_W-1:0]  lg_f;
    logic                ent_valid_bit;

    assign ent_valid_bit = cmd.data[WDATA_W-1];

    xl_map_bank #(.FR_W(SM_FR_W)) u_map_sm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd.we && cmd.sel == TGT_SMALL),
        .wr_idx   (cmd.idx),
        .wr_valid (ent_valid_bit),
        .wr_frame (cmd.data[SM_FR_W-1:0]),
        .rd_idx   (idx_sm),
        .rd_valid (sm_v),
        .rd_frame (sm_f)
    );

    xl_map_bank #(.FR_W(MID_FR_W)) u_map_mid (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd.we && cmd.sel == TGT_MID),
        .wr_idx   (cmd.idx),
        .wr_valid (ent_valid_bit),
        .wr_frame (cmd.data[MID_FR_W-1:0]),
        .rd_idx   (idx_mid),
        .rd_valid (mid_v),
        .rd_frame (mid_f)
    );

    xl_map_bank #(.FR_W(LG_FR_W)) u_map_lg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd.we && cmd.sel == TGT_LARGE),
        .wr_idx   (cmd.idx),
        .wr_valid (ent_valid_bit),
        .wr_frame (cmd.data[LG_FR_W-1:0]),
        .rd_idx   (idx_lg),
        .rd_valid (lg_v),
        .rd_frame (lg_f)
    );

    // translation result
    logic            nx_miss;
    logic [WA_W-1:0] nx_word;

    always_comb begin
        nx_miss = 1'b1;
        nx_word = '0;
        if (hit_sm && sm_v) begin
            nx_miss = 1'b0;
            nx_word = {sm_f, req_addr[SM_SH-1:2]};
        end else if (hit_mid && mid_v) begin
            nx_miss = 1'b0;
            nx_word = {mid_f, req_addr[MID_SH-1:2]};
        end else if (hit_lg && lg_v) begin
            nx_miss = 1'b0;
            nx_word = {lg_f, req_addr[LG_SH-1:2]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xo_valid     <= 1'b0;
            xo_miss      <= 1'b0;
            xo_word_addr <= '0;
            xo_byte_off  <= '0;
        end else begin
            xo_valid <= req_valid;
            if (req_valid) begin
                xo_miss      <= nx_miss;
                xo_word_addr <= nx_word;
                xo_byte_off  <= req_addr[1:0];
            end else begin
                xo_miss      <= 1'b0;
                xo_word_addr <= '0;
                xo_byte_off  <= '0;
            end
        end
    end

    assert_result_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> xo_valid)
        else $error("missing result");

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!xo_valid && !xo_miss && xo_word_addr == '0))
        else $error("result without request");

    assert_byte_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (xo_byte_off == $past(req_addr[1:0])))
        else $error("byte offset wrong");

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xo_miss |-> (xo_word_addr == '0))
        else $error("miss with nonzero address");
endmodule

// File: tb/iob_page_xlate_tb.sv
module iob_page_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        sys_wr_en = 1'b0;
    logic [1:0]  sys_wr_sel = '0;
    logic [3:0]  sys_wr_idx = '0;
    logic [22:0] sys_wr_data = '0;
    logic        per_wr_en = 1'b0;
    logic [1:0]  per_wr_sel = '0;
    logic [3:0]  per_wr_idx = '0;
    logic [22:0] per_wr_data = '0;
    logic        per_wr_stall;
    logic        xo_valid;
    logic [31:0] xo_word_addr;
    logic [1:0]  xo_byte_off;
    logic        xo_miss;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    iob_page_xlate dut_i (.*);

    // bench shadow of everything written
    logic        sm_v [16];
    logic [21:0] sm_f [16];
    logic        md_v [16];
    logic [13:0] md_f [16];
    logic        lg_v [16];
    logic [5:0]  lg_f [16];
    logic [3:0]  m_base;

    task automatic model_apply(input logic [1:0] sel, input logic [3:0] idx, input logic [22:0] d);
        case (sel)
            2'd0: begin sm_v[idx] = d[22]; sm_f[idx] = d[21:0]; end
            2'd1: begin md_v[idx] = d[22]; md_f[idx] = d[13:0]; end
            2'd2: begin lg_v[idx] = d[22]; lg_f[idx] = d[5:0]; end
            default: m_base = d[3:0];
        endcase
    endtask

    task automatic model_xl(input logic [31:0] a, output logic miss, output logic [31:0] w);
        logic [3:0] f;
        miss = 1'b1; w = '0;
        f = a[23:20];
        if (a[31:20] == 0 && a[19:16] == m_base) begin
            if (sm_v[a[15:12]]) begin miss = 1'b0; w = {sm_f[a[15:12]], a[11:2]}; end
        end else if (a[31:24] == 0 && f >= 1 && f <= 14) begin
            if (md_v[f-1]) begin miss = 1'b0; w = {md_f[f-1], a[19:2]}; end
        end else if (a[31:24] != 0) begin
            if (lg_v[a[31:28]]) begin miss = 1'b0; w = {lg_f[a[31:28]], a[27:2]}; end
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_sys(input logic [1:0] sel, input logic [3:0] idx, input logic [22:0] d);
        @(negedge clk);
        sys_wr_en = 1'b1; sys_wr_sel = sel; sys_wr_idx = idx; sys_wr_data = d;
        @(negedge clk);
        sys_wr_en = 1'b0;
        model_apply(sel, idx, d);
    endtask

    task automatic wr_per(input logic [1:0] sel, input logic [3:0] idx, input logic [22:0] d);
        @(negedge clk);
        per_wr_en = 1'b1; per_wr_sel = sel; per_wr_idx = idx; per_wr_data = d;
        @(negedge clk);
        per_wr_en = 1'b0;
        model_apply(sel, idx, d);
    endtask

    task automatic xl_check(input logic [31:0] a, input string req);
        logic em; logic [31:0] ew;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        model_xl(a, em, ew);
        @(negedge clk);
        req_valid = 1'b0;
        check(xo_valid && xo_miss == em && xo_word_addr == ew && xo_byte_off == a[1:0], req,
              $sformatf("addr 0x%08h {valid,miss,word,off}", a),
              {29'd0, xo_valid, xo_miss, xo_word_addr, xo_byte_off},
              {29'd0, 1'b1, em, ew, a[1:0]});
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            sm_v[i] = 0; sm_f[i] = 0; md_v[i] = 0; md_f[i] = 0; lg_v[i] = 0; lg_f[i] = 0;
        end
        m_base = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(!xo_valid && !xo_miss && xo_word_addr == 0 && xo_byte_off == 0 && !per_wr_stall,
              "R1", "outputs in reset", {59'd0, xo_valid, xo_miss, xo_byte_off, per_wr_stall}, 64'd0);
        rst_n = 1'b1;
        // R1: every window misses after reset
        xl_check(32'h0000_0004, "R1");
        xl_check(32'h0010_0000, "R1");
        xl_check(32'h1000_0003, "R1");
        // R7: idle output
        @(negedge clk);
        check(!xo_valid && !xo_miss && xo_word_addr == 0, "R7", "idle result",
              {62'd0, xo_valid, xo_miss}, 64'd0);

        // R8: load maps, system port for small/large, peripheral for middle and base
        for (int i = 0; i < 16; i++)
            wr_sys(2'd0, 4'(i), {(i != 5), 22'((i * 32'h2F1 + 32'h12345) & 32'h3FFFFF)});
        for (int i = 0; i < 16; i++)
            wr_per(2'd1, 4'(i), {(i != 3), 8'hA5, 14'((i * 32'h155 + 32'h21) & 32'h3FFF)});
        for (int i = 0; i < 16; i++)
            wr_sys(2'd2, 4'(i), {(i != 9), 16'h5A5A, 6'((i * 7 + 1) & 6'h3F)});
        wr_per(2'd3, 4'd0, 23'h7FFF0A);   // R8: base register uses data[3:0] only

        // R2: sweep the small window
        for (int i = 0; i < 16; i++) begin
            xl_check({12'h0, 4'hA, 4'(i), 12'h000}, "R2");
            xl_check({12'h0, 4'hA, 4'(i), 12'hFFF}, "R2");
            xl_check({12'h0, 4'hA, 4'(i), 12'h7A5}, "R2");
        end
        // R3: sweep the middle window incl. both unused fields
        for (int i = 0; i < 16; i++) begin
            xl_check({8'h0, 4'(i), 20'h00001}, "R3");
            xl_check({8'h0, 4'(i), 20'hFFFFE}, "R3");
            xl_check({8'h0, 4'(i), 20'h12346}, "R3");
        end
        // R4: sweep the large window
        for (int i = 0; i < 16; i++) begin
            xl_check({4'(i), 28'h1000002}, "R4");
            xl_check({4'(i), 28'hFFFFFFF}, "R4");
        end
        xl_check(32'h0100_0000, "R4");
        xl_check(32'h0FFF_FFFF, "R4");
        // R5: each byte offset
        for (int b = 0; b < 4; b++) xl_check(32'h000A_3100 | 32'(b), "R5");
        // R6: off-window and gap addresses, invalid entries
        xl_check(32'h0009_FFFF, "R6");
        xl_check(32'h000B_0000, "R6");
        xl_check(32'h00F0_0000, "R6");
        xl_check(32'h00FF_FFFC, "R6");
        xl_check(32'h000A_5000, "R6");
        xl_check(32'h0040_0010, "R6");
        xl_check(32'h9000_0000, "R6");

        // R9: write and request in the same cycle sees old contents
        begin
            logic em; logic [31:0] ew;
            @(negedge clk);
            model_xl(32'h000A_1004, em, ew);
            req_valid = 1'b1; req_addr = 32'h000A_1004;
            sys_wr_en = 1'b1; sys_wr_sel = 2'd0; sys_wr_idx = 4'd1; sys_wr_data = {1'b1, 22'h3ABCDE};
            @(negedge clk);
            req_valid = 1'b0; sys_wr_en = 1'b0;
            check(xo_word_addr == ew && !xo_miss, "R9", "same-cycle old value", xo_word_addr, ew);
            model_apply(2'd0, 4'd1, {1'b1, 22'h3ABCDE});
        end
        xl_check(32'h000A_1004, "R9");

        // R10: collision on the same entry
        begin
            @(negedge clk);
            sys_wr_en = 1'b1; sys_wr_sel = 2'd0; sys_wr_idx = 4'd2; sys_wr_data = {1'b1, 22'h111111};
            per_wr_en = 1'b1; per_wr_sel = 2'd0; per_wr_idx = 4'd2; per_wr_data = {1'b1, 22'h222222};
            @(negedge clk);
            sys_wr_en = 1'b0; per_wr_en = 1'b0;
            check(per_wr_stall == 1'b1, "R10", "stall after clash", 64'(per_wr_stall), 64'd1);
            req_valid = 1'b1; req_addr = 32'h000A_2008;
            @(negedge clk);
            req_valid = 1'b0;
            check(xo_word_addr == {22'h111111, 10'h002}, "R10", "system write first",
                  xo_word_addr, {22'h111111, 10'h002});
            check(per_wr_stall == 1'b0, "R10", "stall released", 64'(per_wr_stall), 64'd0);
            model_apply(2'd0, 4'd2, {1'b1, 22'h222222});
        end
        xl_check(32'h000A_2008, "R10");

        // R11: system write during the stall cycle
        begin
            @(negedge clk);
            sys_wr_en = 1'b1; sys_wr_sel = 2'd0; sys_wr_idx = 4'd6; sys_wr_data = {1'b1, 22'h0C0C0C};
            per_wr_en = 1'b1; per_wr_sel = 2'd0; per_wr_idx = 4'd7; per_wr_data = {1'b1, 22'h0D0D0D};
            @(negedge clk);
            per_wr_en = 1'b0;
            sys_wr_idx = 4'd8; sys_wr_data = {1'b1, 22'h0E0E0E};
            check(per_wr_stall == 1'b1, "R11", "stall first cycle", 64'(per_wr_stall), 64'd1);
            @(negedge clk);
            sys_wr_en = 1'b0;
            check(per_wr_stall == 1'b1, "R11", "stall extended", 64'(per_wr_stall), 64'd1);
            @(negedge clk);
            check(per_wr_stall == 1'b0, "R11", "stall ended", 64'(per_wr_stall), 64'd0);
            model_apply(2'd0, 4'd6, {1'b1, 22'h0C0C0C});
            model_apply(2'd0, 4'd8, {1'b1, 22'h0E0E0E});
            model_apply(2'd0, 4'd7, {1'b1, 22'h0D0D0D});
        end
        xl_check(32'h000A_6000, "R11");
        xl_check(32'h000A_7000, "R11");
        xl_check(32'h000A_8000, "R11");

        // R12: peripheral write offered during a stall is dropped
        begin
            @(negedge clk);
            sys_wr_en = 1'b1; sys_wr_sel = 2'd0; sys_wr_idx = 4'd10; sys_wr_data = {1'b1, 22'h0F0F0F};
            per_wr_en = 1'b1; per_wr_sel = 2'd0; per_wr_idx = 4'd11; per_wr_data = {1'b1, 22'h101010};
            @(negedge clk);
            sys_wr_en = 1'b0;
            per_wr_idx = 4'd12; per_wr_data = {1'b0, 22'h131313};
            check(per_wr_stall == 1'b1, "R12", "stall while offering", 64'(per_wr_stall), 64'd1);
            @(negedge clk);
            per_wr_en = 1'b0;
            model_apply(2'd0, 4'd10, {1'b1, 22'h0F0F0F});
            model_apply(2'd0, 4'd11, {1'b1, 22'h101010});
        end
        xl_check(32'h000A_B000, "R12");
        xl_check(32'h000A_C000, "R12");   // entry 12 keeps its old frame

        // R13: move the small window
        wr_sys(2'd3, 4'd0, 23'd3);
        xl_check(32'h000A_4000, "R13");
        for (int i = 0; i < 16; i++) xl_check({12'h0, 4'h3, 4'(i), 12'h404}, "R13");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule